// File: doc/BRIEF.md
# Network Channel Adapter with Inbound Notification

This block is one channel slot of a component wrapper. On one side it faces a network port through two valid/ready word streams, one arriving and one leaving. On the other side it is a slave on the wrapper's internal bus, which carries an enable, a write flag, an address, separate write and read data buses and an interrupt line back to the bus master. The master moves data only while it drives the enable, and learns that new words have arrived from the interrupt, so it never has to poll.

Each direction has its own FIFO, 32 words deep by default. The arriving direction also has a one-word holding register placed ahead of the read port. That register always holds the oldest arrived word whenever one exists, so a data read is answered on the very next clock edge. A second address returns a status word with the fill levels. A build-time parameter picks which paths exist: both directions, the leaving direction only, or the arriving direction only.

Top module: `chanAdapter`

## Requirements
- R1: After reset, busIrq and txValid are low, rxReady and busReady are high, and busRdata is zero. A status read then returns 0x00000005.
- R2: An arriving word is taken on a clock edge where rxValid and rxReady are both high. The arriving side holds up to DEPTH+1 words, counting the holding register. rxReady is low exactly while that many are held.
- R3: A read (busEn high, busWe low) at address 0 places the oldest arriving word on busRdata at the next edge and removes it. Words come out in arrival order, one per cycle on back-to-back reads. A word taken on an edge can be read on the following edge.
- R4: busIrq is high from the edge that takes an arriving word into an empty adapter until the edge of the read that removes the last one.
- R5: A data read while the arriving side is empty returns zero and changes nothing.
- R6: A write (busEn and busWe high) at address 0 accepted with busReady high queues busWdata for the network. txValid is high while words are queued, and txData shows the oldest one. A word leaves on an edge where txValid and txReady are both high.
- R7: While DEPTH words are queued for the network, busReady is low during a data write, and that write is neither taken nor lost. busReady is high in every other cycle.
- R8: A read at address 1 returns the status word at the next edge, built from the state before that edge. Bit 0 is arriving side empty, bit 1 is arriving side full, bit 2 is leaving side empty and bit 3 is leaving side full. Bits 15:8 hold the arriving word count (holding register included), bits 23:16 hold the leaving word count, and all other bits are zero.
- R9: While busEn is low, nothing is read or written, and busRdata keeps its last value.
- R10: Writes to any address other than 0 have no effect. Reads at addresses 2 and above return zero.
- R11: With the DIR parameter set to arriving-only, the leaving path does not exist (txValid stays low and writes vanish). With DIR set to leaving-only, the arriving path does not exist (rxReady and busIrq stay low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busEn | input | 1 | Master selects this adapter for the current cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | 0 = data, 1 = status |
| busWdata | input | DATA_W | Write data from the master |
| busRdata | output | DATA_W | Read result, registered |
| busReady | output | 1 | Low when a data write must be held off |
| busIrq | output | 1 | Arriving data is waiting |
| rxValid | input | 1 | Network offers an arriving word |
| rxData | input | DATA_W | Arriving word |
| rxReady | output | 1 | Adapter can take an arriving word |
| txValid | output | 1 | Adapter offers a leaving word |
| txData | output | DATA_W | Leaving word |
| txReady | input | 1 | Network takes the leaving word |

## Verification
Four outputs are combinational from the registered state: rxReady, busReady, txValid/txData and busIrq. They are due in the same cycle as the stimulus, so the bench compares them a short delay after it drives the inputs and before the next edge. busRdata is registered, so a read result is due one edge after the enabled cycle; the bench samples it one time unit after that edge. Its expected value comes from the model state as it stood before the edge, which also covers the status snapshot taken while words arrive and leave in the same cycle. busIrq is checked in the cycle after each modelled change in the arriving count, which places its rise one edge after the first accepted word and its fall one edge after the last read.

// File: rtl/chanPkg.sv
package chanPkg;

  // which data paths are built
  typedef enum logic [1:0] {
    DIR_INOUT = 2'd0,
    DIR_TX    = 2'd1,
    DIR_RX    = 2'd2
  } chanDirE;

  // source of the registered read result
  typedef enum logic [1:0] {
    SEL_ZERO = 2'd0,
    SEL_DATA = 2'd1,
    SEL_STAT = 2'd2
  } rdSelE;

  // strobes from control to datapath
  typedef struct packed {
    logic  rdLoad;
    rdSelE rdSel;
    logic  inPop;
    logic  outPush;
  } chanStrobeS;

endpackage

// File: rtl/chanFifo.sv
module chanFifo #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  parameter int CNT_W = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] headData,
  output logic [CNT_W-1:0] count,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    full && !pop |=> count == $past(count));

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    empty && !push |=> empty);

endmodule

// File: rtl/chanControl.sv
module chanControl
  import chanPkg::*;
#(
  parameter int ADDR_W = 2,
  parameter bit HAS_TX = 1'b1
) (
  input  logic              busEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              stageValid,
  input  logic              outFull,
  output chanStrobeS        strb,
  output logic              busReady
);
  logic isData, isStat, rdEn, wrData, txBuilt;

  assign txBuilt = HAS_TX;
  assign isData  = (busAddr == '0);
  assign isStat  = (busAddr == ADDR_W'(1));
  assign rdEn    = busEn && !busWe;
  assign wrData  = busEn && busWe && isData;

  always_comb begin
    strb.rdLoad  = rdEn;
    strb.rdSel   = isData ? SEL_DATA : (isStat ? SEL_STAT : SEL_ZERO);
    strb.inPop   = rdEn && isData && stageValid;
    strb.outPush = wrData && txBuilt && !outFull;
  end

  assign busReady = !(wrData && txBuilt && outFull);

endmodule

// File: rtl/chanDatapath.sv
module chanDatapath
  import chanPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  parameter int CNT_W  = 6,
  parameter bit HAS_RX = 1'b1,
  parameter bit HAS_TX = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  chanStrobeS        strb,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              txValid,
  output logic [DATA_W-1:0] txData,
  input  logic              txReady,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busIrq,
  output logic              stageValid,
  output logic              outFull
);
  logic [DATA_W-1:0] stageData;
  logic [CNT_W-1:0]  inCount, outCount;
  logic              inFull;
  logic [DATA_W-1:0] status;

  generate
    if (HAS_RX) begin : gRx
      logic [DATA_W-1:0] headData;
      logic [CNT_W-1:0]  fifoCount;
      logic fifoEmpty, fifoFull, rxAcc, stageFree;
      logic loadFromFifo, loadFromRx, fifoPush;

      assign rxReady      = !fifoFull;
      assign rxAcc        = rxValid && !fifoFull;
      assign stageFree    = !stageValid || strb.inPop;
      assign loadFromFifo = stageFree && !fifoEmpty;
      assign loadFromRx   = stageFree && fifoEmpty && rxAcc;
      assign fifoPush     = rxAcc && !loadFromRx;

      chanFifo #(.W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) inFifo (
        .clk(clk), .rstN(rstN),
        .push(fifoPush), .pushData(rxData),
        .pop(loadFromFifo), .headData(headData),
        .count(fifoCount), .empty(fifoEmpty), .full(fifoFull)
      );

      always_ff @(posedge clk) begin
        if (!rstN) begin
          stageValid <= 1'b0;
          stageData  <= '0;
        end else if (loadFromFifo) begin
          stageValid <= 1'b1;
          stageData  <= headData;
        end else if (loadFromRx) begin
          stageValid <= 1'b1;
          stageData  <= rxData;
        end else if (strb.inPop) begin
          stageValid <= 1'b0;
        end
      end

      assign inCount = fifoCount + CNT_W'(stageValid);
      assign inFull  = fifoFull;
    end else begin : gNoRx
      assign rxReady    = 1'b0;
      assign stageValid = 1'b0;
      assign stageData  = '0;
      assign inCount    = '0;
      assign inFull     = 1'b0;
    end

    if (HAS_TX) begin : gTx
      logic outEmpty;

      chanFifo #(.W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) outFifo (
        .clk(clk), .rstN(rstN),
        .push(strb.outPush), .pushData(busWdata),
        .pop(txValid && txReady), .headData(txData),
        .count(outCount), .empty(outEmpty), .full(outFull)
      );

      assign txValid = !outEmpty;
    end else begin : gNoTx
      assign txValid  = 1'b0;
      assign txData   = '0;
      assign outCount = '0;
      assign outFull  = 1'b0;
    end
  endgenerate

  assign busIrq = (inCount != '0);

  always_comb begin
    status = '0;
    status[0] = (inCount == '0);
    status[1] = inFull;
    status[2] = (outCount == '0);
    status[3] = outFull;
    status[8  +: CNT_W] = inCount;
    status[16 +: CNT_W] = outCount;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata <= '0;
    end else if (strb.rdLoad) begin
      case (strb.rdSel)
        SEL_DATA: busRdata <= stageValid ? stageData : '0;
        SEL_STAT: busRdata <= status;
        default:  busRdata <= '0;
      endcase
    end
  end

  // R4
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busIrq) |-> $past(rxValid && rxReady));

  // R3
  stage_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stageValid) |-> $past(strb.inPop));

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txData));

  // R7
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outFull && !(txValid && txReady) |=> outFull);

endmodule

// File: rtl/chanAdapter.sv
module chanAdapter
  import chanPkg::*;
#(
  parameter int      DATA_W = 32,
  parameter int      DEPTH  = 32,
  parameter int      ADDR_W = 2,
  parameter chanDirE DIR    = DIR_INOUT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busReady,
  output logic              busIrq,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              txValid,
  output logic [DATA_W-1:0] txData,
  input  logic              txReady
);
  localparam bit HAS_RX = (DIR != DIR_TX);
  localparam bit HAS_TX = (DIR != DIR_RX);
  localparam int CNT_W  = $clog2(DEPTH + 2);

  chanStrobeS strb;
  logic       stageValid, outFull;

  chanControl #(.ADDR_W(ADDR_W), .HAS_TX(HAS_TX)) ctrl (
    .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
    .stageValid(stageValid), .outFull(outFull),
    .strb(strb), .busReady(busReady)
  );

  chanDatapath #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W),
    .HAS_RX(HAS_RX), .HAS_TX(HAS_TX)
  ) dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rxValid(rxValid), .rxData(rxData), .rxReady(rxReady),
    .txValid(txValid), .txData(txData), .txReady(txReady),
    .busWdata(busWdata), .busRdata(busRdata), .busIrq(busIrq),
    .stageValid(stageValid), .outFull(outFull)
  );

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busEn |=> $stable(busRdata));

endmodule

// File: tb/chanAdapter_test.sv
`timescale 1ns/1ps
module chanAdapter_test;
  import chanPkg::*;

  localparam int DW = 32;
  localparam int DEPTH = 32;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic          busEn, busWe, txReady, rxValid;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busWdata, rxData;
  logic [DW-1:0] busRdata, txData;
  logic          busReady, busIrq, rxReady, txValid;

  logic [DW-1:0] aRdata, aTxData, bRdata, bTxData;
  logic          aReady, aIrq, aRxReady, aTxValid;
  logic          bReady, bIrq, bRxReady, bTxValid;

  chanAdapter #(.DATA_W(DW), .DEPTH(DEPTH), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady), .busIrq(busIrq),
    .rxValid(rxValid), .rxData(rxData), .rxReady(rxReady),
    .txValid(txValid), .txData(txData), .txReady(txReady));

  chanAdapter #(.DATA_W(DW), .DEPTH(DEPTH), .ADDR_W(AW), .DIR(DIR_RX)) uutRxOnly (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(aRdata), .busReady(aReady), .busIrq(aIrq),
    .rxValid(rxValid), .rxData(rxData), .rxReady(aRxReady),
    .txValid(aTxValid), .txData(aTxData), .txReady(txReady));

  chanAdapter #(.DATA_W(DW), .DEPTH(DEPTH), .ADDR_W(AW), .DIR(DIR_TX)) uutTxOnly (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(bRdata), .busReady(bReady), .busIrq(bIrq),
    .rxValid(rxValid), .rxData(rxData), .rxReady(bRxReady),
    .txValid(bTxValid), .txData(bTxData), .txReady(txReady));

  int errs = 0;
  int checks = 0;
  logic [DW-1:0] inQ[$];
  logic [DW-1:0] outQ[$];
  logic [DW-1:0] lastRd = '0;

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] expStat(int inN, int outN);
    logic [DW-1:0] s = '0;
    s[0] = (inN == 0);
    s[1] = (inN == DEPTH + 1);
    s[2] = (outN == 0);
    s[3] = (outN == DEPTH);
    s[15:8]  = 8'(inN);
    s[23:16] = 8'(outN);
    return s;
  endfunction

  // op: 0 idle, 1 read, 2 write, 3 write with busEn low
  task automatic tick(bit rxV, logic [DW-1:0] rxD, int op, logic [AW-1:0] a,
                      logic [DW-1:0] wd, bit txR, string tag);
    int inN = inQ.size();
    int outN = outQ.size();
    bit rxAcc, wrAcc, rdPop, txPop;
    logic [DW-1:0] expRd;
    rxValid = rxV; rxData = rxD;
    busEn = (op == 1 || op == 2); busWe = (op == 2 || op == 3);
    busAddr = a; busWdata = wd; txReady = txR;
    #2;
    chk("R2 rxReady", 32'(rxReady), 32'(inN < DEPTH + 1));
    chk("R7 busReady", 32'(busReady), 32'((op == 2 && a == 0) ? (outN < DEPTH) : 1));
    chk("R6 txValid", 32'(txValid), 32'(outN > 0));
    if (outN > 0) chk("R6 txData", txData, outQ[0]);
    chk("R4 busIrq", 32'(busIrq), 32'(inN > 0));
    chk("R11 rx-only txValid", 32'(aTxValid), 32'(0));
    chk("R11 rx-only busIrq", 32'(aIrq), 32'(inN > 0));
    chk("R11 tx-only rxReady", 32'(bRxReady), 32'(0));
    chk("R11 tx-only busIrq", 32'(bIrq), 32'(0));
    chk("R11 tx-only txValid", 32'(bTxValid), 32'(outN > 0));
    rxAcc = rxV && (inN < DEPTH + 1);
    wrAcc = (op == 2) && (a == 0) && (outN < DEPTH);
    rdPop = (op == 1) && (a == 0) && (inN > 0);
    txPop = txR && (outN > 0);
    if (op == 1) begin
      if (a == 0)      expRd = (inN > 0) ? inQ[0] : '0;
      else if (a == 1) expRd = expStat(inN, outN);
      else             expRd = '0;
    end else begin
      expRd = lastRd;
    end
    @(posedge clk); #1;
    if (rdPop) void'(inQ.pop_front());
    if (rxAcc) inQ.push_back(rxD);
    if (txPop) void'(outQ.pop_front());
    if (wrAcc) outQ.push_back(wd);
    chk((op == 1) ? tag : "R9 busRdata hold", busRdata, expRd);
    lastRd = expRd;
  endtask

  initial begin
    busEn = 0; busWe = 0; busAddr = '0; busWdata = '0;
    rxValid = 0; rxData = '0; txReady = 0;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    chk("R1 busIrq", 32'(busIrq), 32'(0));
    chk("R1 txValid", 32'(txValid), 32'(0));
    chk("R1 rxReady", 32'(rxReady), 32'(1));
    chk("R1 busReady", 32'(busReady), 32'(1));
    chk("R1 busRdata", busRdata, 32'(0));
    @(posedge clk); #1;
    tick(0, 0, 1, 1, 0, 0, "R1 status after reset");
    chk("R1 status value", busRdata, 32'h0000_0005);

    tick(0, 0, 1, 0, 0, 0, "R5 empty read");
    tick(0, 0, 1, 1, 0, 0, "R5 status unchanged");

    tick(1, 32'h1111_0001, 0, 0, 0, 0, "R4");
    tick(0, 0, 1, 0, 0, 0, "R3 single read");
    tick(0, 0, 0, 0, 0, 0, "R4");
    tick(1, 32'h1111_0002, 1, 0, 0, 0, "R5 read during arrival");
    tick(0, 0, 1, 0, 0, 0, "R3 read next edge");

    for (int i = 0; i < DEPTH + 2; i++) tick(1, 32'hA000_0000 + i, 0, 0, 0, 0, "R2");
    tick(0, 0, 1, 1, 0, 0, "R8 status arriving full");
    tick(1, 32'hDEAD_0000, 0, 0, 0, 0, "R2 refused");
    for (int i = 0; i < DEPTH + 1; i++) tick(0, 0, 1, 0, 0, 0, "R3 back-to-back order");
    tick(0, 0, 1, 1, 0, 0, "R8 status after drain");

    for (int i = 0; i < DEPTH + 1; i++) tick(0, 0, 2, 0, 32'hB000_0000 + i, 0, "R7");
    tick(0, 0, 1, 1, 0, 0, "R8 status leaving full");
    tick(0, 0, 2, 0, 32'hBAD0_0001, 0, "R7 stalled write");
    tick(0, 0, 3, 0, 32'hBAD0_0002, 0, "R9");
    tick(0, 0, 3, 1, 32'hBAD0_0003, 0, "R9");
    tick(0, 0, 2, 1, 32'hBAD0_0004, 0, "R10");
    tick(0, 0, 2, 2, 32'hBAD0_0005, 0, "R10");
    tick(0, 0, 2, 3, 32'hBAD0_0006, 0, "R10");
    tick(0, 0, 1, 2, 0, 0, "R10 high address reads zero");
    tick(0, 0, 1, 1, 0, 0, "R10 status unaffected");
    for (int i = 0; i < DEPTH + 1; i++) tick(0, 0, 0, 0, 0, 1, "R6");
    tick(0, 0, 1, 1, 0, 0, "R8 status both empty");

    for (int i = 0; i < 3000; i++) begin
      bit fillPhase = ((i / 300) % 2) == 0;
      int r = $urandom % 8;
      int op = (r < 3) ? 0 : (r < (fillPhase ? 4 : 6)) ? 1 : 2;
      logic [AW-1:0] a = (($urandom % 6) == 0) ? AW'($urandom % 4) : '0;
      bit rxV = fillPhase ? (($urandom % 4) != 0) : (($urandom % 4) == 0);
      bit txR = fillPhase ? (($urandom % 5) == 0) : (($urandom % 5) != 0);
      tick(rxV, $urandom, op, a, $urandom, txR, "R3 R8 random");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errs++;
    $display("FAIL watchdog (R1..R11 unfinished) actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule